// File: doc/BRIEF.md
# SDRAM Bank Timing Enforcer

This block watches the command strobes that a memory controller sends to one SDRAM bank and tells the controller when the next command of each kind is allowed. It holds a 64-bit programmable timing register. Each coded field in that register is turned into a number of clock cycles. Small counters use those numbers to track five intervals:

- activate to read/write;
- activate to precharge;
- precharge to activate;
- activate (or refresh) to the next activate;
- last write data to activate.

The controller reads three ready flags, one for a column access, one for a precharge and one for an activate. It only issues a command when the matching flag is high.

The timing fields are captured into a private snapshot when an ACTIVE or REFRESH command is accepted. Software can therefore rewrite the register at any time without disturbing the access that is in progress.

For short reads (one beat or two beats), the activate-to-activate spacing is reduced to the activate-to-precharge time plus the precharge time plus one clock, whenever that sum is shorter than the programmed bank cycle time. If a reserved code is written into a field, the block uses that field's slowest legal timing and raises a sticky error flag.

Top module: `bank_timer`

## Requirements
- R1: The register stores bits 33:25 as written and reads them back on `reg_rdata` in the same cycle. All other bits read as zero and ignore writes. After reset `reg_rdata` is 64'h0000_0003_BE00_0000.
- R2: Bit 25 sets tRCD: 0 means 2 clocks and 1 means 3 clocks. `ok_to_readwrite` is low while the bank is closed. After an ACTIVE accepted at edge k, it is high only from the cycle before edge k+tRCD onward, until a PRECHARGE.
- R3: Bits 28:27 set tRAS: codes 0,1,2,3 give 3,4,5,6 clocks. `ok_to_precharge` is low while the bank is closed. After an ACTIVE at edge k, a PRECHARGE is allowed no earlier than edge k+tRAS.
- R4: Bit 26 sets tRP: 0 means 2 clocks and 1 means 3 clocks. After a PRECHARGE at edge k, `ok_to_activate` stays low until edge k+tRP is reached, and it is always low while the bank is open.
- R5: Bits 31:29 set tRC: codes 0 to 5 give 5 to 10 clocks. After an ACTIVE or REFRESH at edge k, the next ACTIVE or REFRESH is allowed no earlier than edge k+tRC.
- R6: After an ACTIVE, a READ accepted with `rd_short` high (one-beat or two-beat read) changes the spacing to the next activate. It becomes tRAS+tRP+1 when tRAS+tRP < tRC, and stays tRC otherwise. A following ACTIVE or REFRESH restores the full tRC.
- R7: Bits 33:32 set the write-data-to-activate time: codes 1,2,3 give 4,5,6 clocks. After `wr_last` at edge k, `ok_to_activate` stays low until edge k+that time.
- R8: Any write with code 0 in bits 33:32 uses 6 clocks for that field. Any write with code 6 or 7 in bits 31:29 uses 10 clocks for that field. Either case sets `config_error`, which then stays high until reset.
- R9: The intervals use the field values captured at the latest ACTIVE or REFRESH. A register write after that point has no effect until the next ACTIVE or REFRESH.
- R10: After reset the bank is closed: `ok_to_activate` is 1, and `ok_to_readwrite`, `ok_to_precharge` and `config_error` are 0.
- R11: A command strobe while its ready flag is low is flagged by an assertion. ACTIVE and REFRESH need `ok_to_activate`, READ and WRITE need `ok_to_readwrite`, and PRECHARGE needs `ok_to_precharge`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Timing register write enable |
| reg_wdata | input | 64 | Timing register write data |
| reg_rdata | output | 64 | Timing register read data |
| cmd_act | input | 1 | ACTIVE command accepted this cycle |
| cmd_rd | input | 1 | READ command accepted this cycle |
| cmd_wr | input | 1 | WRITE command accepted this cycle |
| cmd_pre | input | 1 | PRECHARGE command accepted this cycle |
| cmd_ref | input | 1 | REFRESH command accepted this cycle |
| wr_last | input | 1 | Last write data beat this cycle |
| rd_short | input | 1 | Qualifies `cmd_rd` as a one-beat or two-beat read |
| ok_to_readwrite | output | 1 | READ/WRITE allowed at the next edge |
| ok_to_precharge | output | 1 | PRECHARGE allowed at the next edge |
| ok_to_activate | output | 1 | ACTIVE/REFRESH allowed at the next edge |
| config_error | output | 1 | Sticky flag: a reserved code was written |

## Verification
A counter loaded with the wrong value, or loaded from live fields instead of the snapshot, moves the edge of a ready flag. That shows up at the ports in the very cycle the flag should have risen or fallen, within at most ten clocks of the command that started the interval.

A wrong open/closed bank state shows up one cycle after the ACTIVE or PRECHARGE, as a column or activate flag with the wrong value. A lost short-read flag or an unsaturated reserved code shifts the `ok_to_activate` edge by one or more cycles on the next bank cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

    localparam int REG_W    = 64;
    localparam int CNT_W    = 4;
    localparam int DAL_LO   = 32;
    localparam int TRC_LO   = 29;
    localparam int TRAS_LO  = 27;
    localparam int TRP_BIT  = 26;
    localparam int TRCD_BIT = 25;
    localparam int N_DOWN   = 4;

    localparam logic [REG_W-1:0] REG_RESET = 64'h0000_0003_BE00_0000;
    localparam logic [REG_W-1:0] REG_MASK  = 64'h0000_0003_FE00_0000;

    typedef logic [CNT_W-1:0] cyc_t;

    typedef struct packed {
        cyc_t trcd;
        cyc_t tras;
        cyc_t trp;
        cyc_t trc;
        cyc_t tdal;
        cyc_t trc_short;
    } timing_t;

    typedef enum int {
        CT_RCD = 0,
        CT_RAS = 1,
        CT_RP  = 2,
        CT_DAL = 3
    } down_idx_e;

    function automatic cyc_t dec_two_three(input logic b);
        return b ? cyc_t'(3) : cyc_t'(2);
    endfunction

    function automatic cyc_t dec_tras(input logic [1:0] c);
        return cyc_t'(c) + cyc_t'(3);
    endfunction

    function automatic cyc_t dec_trc(input logic [2:0] c);
        return (c > 3'd5) ? cyc_t'(10) : cyc_t'(c) + cyc_t'(5);
    endfunction

    function automatic cyc_t dec_dal(input logic [1:0] c);
        return (c == 2'd0) ? cyc_t'(6) : cyc_t'(c) + cyc_t'(3);
    endfunction

    function automatic logic has_reserved(input logic [REG_W-1:0] r);
        return (r[DAL_LO+1:DAL_LO] == 2'd0) || (r[TRC_LO+2:TRC_LO] > 3'd5);
    endfunction

    function automatic timing_t decode(input logic [REG_W-1:0] r);
        timing_t t;
        t.trcd = dec_two_three(r[TRCD_BIT]);
        t.trp  = dec_two_three(r[TRP_BIT]);
        t.tras = dec_tras(r[TRAS_LO+1:TRAS_LO]);
        t.trc  = dec_trc(r[TRC_LO+2:TRC_LO]);
        t.tdal = dec_dal(r[DAL_LO+1:DAL_LO]);
        t.trc_short = ((t.tras + t.trp) < t.trc) ? (t.tras + t.trp + cyc_t'(1)) : t.trc;
        return t;
    endfunction

endpackage

// File: rtl/bt_cfg_reg.sv
module bt_cfg_reg
    import bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output timing_t          live,
    output logic             cfg_err
);

    logic [REG_W-1:0] store_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= REG_RESET;
            cfg_err <= 1'b0;
        end else if (we) begin
            store_q <= wdata & REG_MASK;
            if (has_reserved(wdata)) begin
                cfg_err <= 1'b1;
            end
        end
    end

    assign rdata = store_q;
    assign live  = decode(store_q);

    // R8: the error flag never clears on its own
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

endmodule

// File: rtl/bt_down_cnt.sv
module bt_down_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/bt_cycle_win.sv
module bt_cycle_win #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         shorten,
    input  logic [W-1:0] lim_full,
    input  logic [W-1:0] lim_short,
    output logic         expired
);

    localparam logic [W-1:0] SAT = '1;

    logic [W-1:0] since_q;
    logic         short_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_q <= SAT;
            short_q <= 1'b0;
        end else if (start) begin
            since_q <= W'(1);
            short_q <= 1'b0;
        end else begin
            if (since_q != SAT) begin
                since_q <= since_q + 1'b1;
            end
            if (shorten) begin
                short_q <= 1'b1;
            end
        end
    end

    assign expired = since_q >= (short_q ? lim_short : lim_full);

    // R5: every bank cycle lasts at least two clocks
    a_r5_window_closed_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> !expired);

endmodule

// File: rtl/bank_timer.sv
module bank_timer
    import bt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             cmd_act,
    input  logic             cmd_rd,
    input  logic             cmd_wr,
    input  logic             cmd_pre,
    input  logic             cmd_ref,
    input  logic             wr_last,
    input  logic             rd_short,
    output logic             ok_to_readwrite,
    output logic             ok_to_precharge,
    output logic             ok_to_activate,
    output logic             config_error
);

    timing_t live;
    timing_t snap_q;
    logic    open_q;
    logic    win_expired;
    logic    cycle_start;

    logic [N_DOWN-1:0] ld;
    cyc_t              lv [N_DOWN];
    logic [N_DOWN-1:0] zr;

    bt_cfg_reg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .live    (live),
        .cfg_err (config_error)
    );

    assign cycle_start = cmd_act | cmd_ref;

    always_ff @(posedge clk) begin
        if (rst) begin
            snap_q <= decode(REG_RESET);
        end else if (cycle_start) begin
            snap_q <= live;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
        end else if (cmd_act) begin
            open_q <= 1'b1;
        end else if (cmd_pre) begin
            open_q <= 1'b0;
        end
    end

    // Intervals begun by ACTIVE take the fields being captured now;
    // later intervals take the captured copy.
    assign ld[CT_RCD] = cmd_act;
    assign lv[CT_RCD] = live.trcd - cyc_t'(1);
    assign ld[CT_RAS] = cmd_act;
    assign lv[CT_RAS] = live.tras - cyc_t'(1);
    assign ld[CT_RP]  = cmd_pre;
    assign lv[CT_RP]  = snap_q.trp - cyc_t'(1);
    assign ld[CT_DAL] = wr_last;
    assign lv[CT_DAL] = snap_q.tdal - cyc_t'(1);

    for (genvar i = 0; i < N_DOWN; i++) begin : g_down
        bt_down_cnt #(.W(CNT_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .load     (ld[i]),
            .load_val (lv[i]),
            .zero     (zr[i])
        );
    end

    bt_cycle_win #(.W(CNT_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .start     (cycle_start),
        .shorten   (cmd_rd & rd_short),
        .lim_full  (snap_q.trc),
        .lim_short (snap_q.trc_short),
        .expired   (win_expired)
    );

    assign ok_to_readwrite = open_q & zr[CT_RCD];
    assign ok_to_precharge = open_q & zr[CT_RAS];
    assign ok_to_activate  = ~open_q & zr[CT_RP] & zr[CT_DAL] & win_expired;

    // R11: commands only while their ready flag is high
    a_r11_act_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_act |-> ok_to_activate);
    a_r11_ref_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_ref |-> ok_to_activate);
    a_r11_rd_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |-> ok_to_readwrite);
    a_r11_wr_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |-> ok_to_readwrite);
    a_r11_pre_ready: assert property (@(posedge clk) disable iff (rst)
        cmd_pre |-> ok_to_precharge);

    // R2: tRCD of at least two clocks blocks a column access right after ACTIVE
    a_r2_rw_blocked_after_act: assert property (@(posedge clk) disable iff (rst)
        cmd_act |=> !ok_to_readwrite);
    // R3: precharge blocked right after ACTIVE
    a_r3_pre_blocked_after_act: assert property (@(posedge clk) disable iff (rst)
        cmd_act |=> !ok_to_precharge);
    // R4: activate blocked right after PRECHARGE
    a_r4_act_blocked_after_pre: assert property (@(posedge clk) disable iff (rst)
        cmd_pre |=> !ok_to_activate);
    // R4: activate and column access are never allowed together
    a_r4_open_closed_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(ok_to_activate && ok_to_readwrite));

endmodule

// File: tb/sim_bank_timer.sv
`timescale 1ns/1ps
module sim_bank_timer;

    localparam real CLK_NS = 8.0;
    localparam logic [63:0] MASK = 64'h0000_0003_FE00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        cmd_act = 0, cmd_rd = 0, cmd_wr = 0, cmd_pre = 0, cmd_ref = 0;
    logic        wr_last = 0, rd_short = 0;
    logic        ok_rw, ok_pre, ok_act, cfg_err;

    int total = 0;
    int bad = 0;

    always #(CLK_NS / 2.0) clk = ~clk;

    bank_timer u0 (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cmd_act(cmd_act), .cmd_rd(cmd_rd),
        .cmd_wr(cmd_wr), .cmd_pre(cmd_pre), .cmd_ref(cmd_ref),
        .wr_last(wr_last), .rd_short(rd_short),
        .ok_to_readwrite(ok_rw), .ok_to_precharge(ok_pre),
        .ok_to_activate(ok_act), .config_error(cfg_err)
    );

    // model state, edge indices
    int          e = 0;
    logic        m_open = 0, m_short = 0, m_err = 0;
    int          t_act = -100, t_pre = -100, t_rc = -100, t_wl = -100;
    logic [63:0] m_reg = 64'h0000_0003_BE00_0000;
    int          s_trcd = 3, s_tras = 6, s_trp = 3, s_trc = 10, s_tdal = 6, s_eff = 10;

    function automatic int f_trcd(logic [63:0] r); return r[25] ? 3 : 2; endfunction
    function automatic int f_trp(logic [63:0] r);  return r[26] ? 3 : 2; endfunction
    function automatic int f_tras(logic [63:0] r); return 3 + int'(r[28:27]); endfunction
    function automatic int f_trc(logic [63:0] r);
        return (r[31:29] > 3'd5) ? 10 : 5 + int'(r[31:29]);
    endfunction
    function automatic int f_tdal(logic [63:0] r);
        return (r[33:32] == 2'd0) ? 6 : 3 + int'(r[33:32]);
    endfunction

    function automatic logic x_rw(int n);  return m_open && (n - t_act >= s_trcd); endfunction
    function automatic logic x_pre(int n); return m_open && (n - t_act >= s_tras); endfunction
    function automatic logic x_act(int n);
        int lim;
        lim = m_short ? s_eff : s_trc;
        return !m_open && (n - t_pre >= s_trp) && (n - t_rc >= lim) && (n - t_wl >= s_tdal);
    endfunction

    task automatic chk(string tag, string what, logic [63:0] act_v, logic [63:0] exp_v);
        total++;
        if (act_v !== exp_v) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h (edge %0d)", tag, what, act_v, exp_v, e);
        end
    endtask

    task automatic snapshot();
        s_trcd = f_trcd(m_reg); s_tras = f_tras(m_reg); s_trp = f_trp(m_reg);
        s_trc = f_trc(m_reg); s_tdal = f_tdal(m_reg);
        s_eff = (s_tras + s_trp < s_trc) ? s_tras + s_trp + 1 : s_trc;
    endtask

    // cmd: 0 idle, 1 act, 2 rd, 3 wr, 4 pre, 5 ref; illegal ones become idle
    task automatic drive(string tag, int cmd, logic sh, logic wl, logic we, logic [63:0] wd);
        int n;
        @(negedge clk);
        n = e + 1;
        chk(tag, "R2 ok_to_readwrite", 64'(ok_rw), 64'(x_rw(n)));
        chk(tag, "R3 ok_to_precharge", 64'(ok_pre), 64'(x_pre(n)));
        chk(tag, "R4 R5 R6 R7 ok_to_activate", 64'(ok_act), 64'(x_act(n)));
        chk(tag, "R8 config_error", 64'(cfg_err), 64'(m_err));
        chk(tag, "R1 reg_rdata", reg_rdata, m_reg);
        if ((cmd == 1 || cmd == 5) && !x_act(n)) cmd = 0;
        if ((cmd == 2 || cmd == 3) && !x_rw(n)) cmd = 0;
        if (cmd == 4 && !x_pre(n)) cmd = 0;
        cmd_act = (cmd == 1); cmd_rd = (cmd == 2); cmd_wr = (cmd == 3);
        cmd_pre = (cmd == 4); cmd_ref = (cmd == 5);
        rd_short = sh; wr_last = wl; reg_we = we; reg_wdata = wd;
        case (cmd)
            1: begin snapshot(); m_open = 1; t_act = n; t_rc = n; m_short = 0; end
            2: if (sh) m_short = 1;
            4: begin m_open = 0; t_pre = n; end
            5: begin snapshot(); t_rc = n; m_short = 0; end
            default: ;
        endcase
        if (wl) t_wl = n;
        if (we) begin
            m_reg = wd & MASK;
            if (wd[33:32] == 2'd0 || wd[31:29] > 3'd5) m_err = 1;
        end
        e = n;
    endtask

    task automatic idle(string tag, int k);
        for (int i = 0; i < k; i++) drive(tag, 0, 0, 0, 0, '0);
    endtask

    function automatic logic [63:0] cfg(int dal, int trc, int tras, int trp, int trcd);
        return (64'(dal) << 32) | (64'(trc) << 29) | (64'(tras) << 27)
             | (64'(trp) << 26) | (64'(trcd) << 25);
    endfunction

    initial begin
        #(CLK_NS * 200000.0);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] wd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state and R1 reset readback
        idle("R10", 2);

        // R9: program fast timing right after ACTIVE; current access keeps old timing
        drive("R9", 1, 0, 0, 0, '0);
        drive("R9", 0, 0, 0, 1, cfg(1, 0, 0, 0, 0));
        for (int i = 0; i < 8; i++) drive("R9", 4, 0, 0, 0, '0);
        for (int i = 0; i < 12; i++) drive("R9", 1, 0, 0, 0, '0);
        for (int i = 0; i < 12; i++) drive("R9", 4, 0, 0, 0, '0);

        // R6: tRC=10, tRAS=3, tRP=2 -> short cycle 6
        drive("R6", 0, 0, 0, 1, cfg(1, 5, 0, 0, 0));
        for (int i = 0; i < 12; i++) drive("R6", 1, 0, 0, 0, '0);
        for (int i = 0; i < 4; i++) drive("R6", 2, 1, 0, 0, '0);
        for (int i = 0; i < 6; i++) drive("R6", 4, 0, 0, 0, '0);
        for (int i = 0; i < 12; i++) drive("R6", 1, 0, 0, 0, '0);
        for (int i = 0; i < 6; i++) drive("R5", 4, 0, 0, 0, '0);
        for (int i = 0; i < 12; i++) drive("R5", 5, 0, 0, 0, '0);

        // R7: write then last data, activate waits
        for (int i = 0; i < 12; i++) drive("R7", 1, 0, 0, 0, '0);
        for (int i = 0; i < 4; i++) drive("R7", 3, 0, 0, 0, '0);
        drive("R7", 4, 0, 1, 0, '0);
        for (int i = 0; i < 10; i++) drive("R7", 1, 0, 0, 0, '0);

        // R8: reserved codes saturate and set sticky error
        drive("R8", 0, 0, 0, 1, cfg(0, 7, 3, 1, 1));
        idle("R8", 3);
        for (int i = 0; i < 14; i++) drive("R8", 4, 0, 0, 0, '0);
        for (int i = 0; i < 14; i++) drive("R8", 1, 0, 0, 0, '0);
        drive("R8", 0, 0, 0, 1, cfg(2, 1, 1, 0, 1));
        idle("R8", 2);

        // constrained random phase, fixed seed
        void'($urandom(32'd20240611));
        for (int i = 0; i < 5000; i++) begin
            int c;
            logic we;
            c = int'($urandom % 10);
            if (c > 5) c = 0;
            we = ($urandom % 40) == 0;
            wd = {$urandom, $urandom};
            drive("RND", c, 1'($urandom % 2), ($urandom % 8) == 0, we, wd);
        end

        cmd_act = 0; cmd_rd = 0; cmd_wr = 0; cmd_pre = 0; cmd_ref = 0;
        wr_last = 0; reg_we = 0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule